// File: doc/BRIEF.md
# Periodic Program Restart Sequencer

This block decides when a small always-on program engine is allowed to run. Software configures five sleep-period registers, picks one of them with a selector, and issues a run command that carries the program entry address. The engine is then started at once. Each time the engine reports that it has halted, the sequencer counts idle cycles up to the selected period and then starts the engine again at the same entry address.

The sequencer also watches the instruction stream of the engine for two control instructions. The first is a period-select instruction, which lets the running program choose a different sleep period. The second is a wake instruction, which sends a one-cycle wake request to the host and leaves the program running. The program, or software through the configuration port, can clear the timer enable. When it is clear, no further automatic restart happens until software issues a new run command. The low-power clock that drives the block comes from outside.

Top module: `sleepSequencer`

## Requirements
- R1: After reset, `coreStart` and `wakeOut` are low, `startAddr` is 0, the selector is 0 and the timer is disabled.
- R2: A configuration write at address 0 to 4 loads period register 0 to 4 with `cfgWrData`. A write at address 6 sets the timer enable to `cfgWrData[0]`.
- R3: A run command loads `startAddr` from `runAddr` and sets the timer enable. It raises `coreStart` for exactly one cycle, in the cycle after the command. `startAddr` changes only on a run command.
- R4: A halt while running with the timer enabled clears the counter. `coreStart` then pulses P+1 cycles after the halt cycle, where P is the selected period. A period of 0 restarts in the very next cycle, and the engine restarts at the unchanged `startAddr`.
- R5: A configuration write at address 5 with a value from 0 to 4 sets the selector. A value of 5 or more is ignored and the previous selection stays in place.
- R6: A period-select instruction loads the selector from `instr[3:0]`. This instruction has `instr[31:28]`=9 and `instr[27:25]`=1, and is qualified by `instrValid`. A value of 5 or more is ignored.
- R7: A wake instruction raises `wakeOut` for exactly one cycle, in the cycle after it is presented. This instruction has `instr[31:28]`=9, `instr[27:25]`=0 and `instr[0]`=1. It does not start the engine, and periodic restarts continue afterwards. With `instr[0]`=0 it produces no wake.
- R8: With the timer enable clear, a halt leads to no restart. Clearing the enable while the counter runs cancels the pending restart. A later run command restarts the engine.
- R9: A halt while the engine is not running is ignored and produces no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power sequencing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWrData | input | PERIOD_W | Configuration write data |
| runCmd | input | 1 | Software run command |
| runAddr | input | ADDR_W | Entry address for the run command |
| coreHalt | input | 1 | Engine reports it has halted |
| instrValid | input | 1 | Engine instruction qualifier |
| instr | input | 32 | Instruction being executed by the engine |
| coreStart | output | 1 | One-cycle start pulse to the engine |
| startAddr | output | ADDR_W | Program entry address for the engine |
| wakeOut | output | 1 | One-cycle host wake request |

## Verification
Three results have fixed latencies. The start pulse after a run command is due in the next cycle, and so is the wake pulse after a wake instruction. The start pulse after a halt is due P+1 cycles later for a selected period P. The bench drives every stimulus on a falling edge and then counts falling edges until the start pulse appears. It compares that count with P+1, so a restart that is one cycle early or late shows up as a latency mismatch. Pulse widths are checked by sampling the falling edge after the expected pulse. Cases where nothing should happen are checked by watching `coreStart` over a long window.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int NUM_PERIODS = 5;
  localparam int SEL_W       = 3;
  localparam int CFG_AW      = 3;
  localparam int INSTR_W     = 32;

  localparam logic [CFG_AW-1:0] CFG_SEL_ADDR = 3'd5;
  localparam logic [CFG_AW-1:0] CFG_CTL_ADDR = 3'd6;

  localparam logic [3:0] OP_STOP      = 4'd9;
  localparam logic [2:0] SUB_WAKE     = 3'd0;
  localparam logic [2:0] SUB_SLEEPSEL = 3'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } seqState_e;

  typedef struct packed {
    logic       cntClr;
    logic       cntInc;
    logic       selLoad;
    logic [3:0] selReq;
  } seqStrobe_t;

  function automatic logic isSleepSel(input logic [INSTR_W-1:0] word);
    return (word[31:28] == OP_STOP) && (word[27:25] == SUB_SLEEPSEL);
  endfunction

  function automatic logic isWake(input logic [INSTR_W-1:0] word);
    return (word[31:28] == OP_STOP) && (word[27:25] == SUB_WAKE) && word[0];
  endfunction
endpackage

// File: rtl/seqData.sv
module seqData
  import seqPkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int ADDR_W   = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [PERIOD_W-1:0] cfgWrData,
  input  logic                runCmd,
  input  logic [ADDR_W-1:0]   runAddr,
  input  seqStrobe_t          strobe,
  output logic                timerEn,
  output logic                restartDue,
  output logic [ADDR_W-1:0]   startAddr
);
  localparam logic [PERIOD_W-1:0] NUM_P_W = PERIOD_W'(NUM_PERIODS);

  logic [PERIOD_W-1:0] periodReg [NUM_PERIODS];
  logic [SEL_W-1:0]    selIdx;
  logic [PERIOD_W-1:0] selPeriod;
  logic [PERIOD_W-1:0] sleepCnt;

  // one write-decoded register per period slot
  for (genvar g = 0; g < NUM_PERIODS; g++) begin : gPeriod
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) periodReg[g] <= '0;
      else if (cfgWrEn && cfgAddr == CFG_AW'(g)) periodReg[g] <= cfgWrData;
    end
  end

  // selector: program instruction wins over a same-cycle software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx <= '0;
    end else if (strobe.selLoad && strobe.selReq < 4'(NUM_PERIODS)) begin
      selIdx <= SEL_W'(strobe.selReq);
    end else if (cfgWrEn && cfgAddr == CFG_SEL_ADDR && cfgWrData < NUM_P_W) begin
      selIdx <= SEL_W'(cfgWrData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerEn   <= 1'b0;
      startAddr <= '0;
    end else if (runCmd) begin
      timerEn   <= 1'b1;
      startAddr <= runAddr;
    end else if (cfgWrEn && cfgAddr == CFG_CTL_ADDR) begin
      timerEn   <= cfgWrData[0];
    end
  end

  always_comb begin
    selPeriod = '0;
    for (int k = 0; k < NUM_PERIODS; k++) begin
      if (selIdx == SEL_W'(k)) selPeriod = periodReg[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sleepCnt <= '0;
    else if (strobe.cntClr) sleepCnt <= '0;
    else if (strobe.cntInc) sleepCnt <= sleepCnt + 1'b1;
  end

  // >= keeps a shortened period from letting the counter wrap
  assign restartDue = (sleepCnt >= selPeriod);

  a_r5_sel_in_range: assert property (@(posedge clk) disable iff (!rstN)
    selIdx < SEL_W'(NUM_PERIODS));

  a_r3_addr_only_on_run: assert property (@(posedge clk) disable iff (!rstN)
    !runCmd |=> $stable(startAddr));

  a_r4_cnt_cleared_on_halt: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> sleepCnt == '0);
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               runCmd,
  input  logic               coreHalt,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               timerEn,
  input  logic               restartDue,
  output seqStrobe_t         strobe,
  output logic               coreStart,
  output logic               wakeOut
);
  seqState_e state, stateNext;
  logic      startNext;

  always_comb begin
    stateNext      = state;
    startNext      = 1'b0;
    strobe         = '0;
    strobe.selLoad = instrValid && isSleepSel(instr);
    strobe.selReq  = instr[3:0];
    if (runCmd) begin
      stateNext = ST_RUN;
      startNext = 1'b1;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (coreHalt) begin
            stateNext     = timerEn ? ST_SLEEP : ST_IDLE;
            strobe.cntClr = timerEn;
          end
        end
        ST_SLEEP: begin
          if (!timerEn) begin
            stateNext = ST_IDLE;
          end else if (restartDue) begin
            stateNext = ST_RUN;
            startNext = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      coreStart <= 1'b0;
      wakeOut   <= 1'b0;
    end else begin
      state     <= stateNext;
      coreStart <= startNext;
      wakeOut   <= instrValid && isWake(instr);
    end
  end

  a_r4_start_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |-> $past(runCmd) || ($past(state) == ST_SLEEP && $past(timerEn)));

  a_r7_wake_from_instr: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> $past(instrValid) && $past(instr[0]));

  a_r9_idle_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !runCmd) |=> !coreStart);

  a_r8_disabled_halt_idles: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && coreHalt && !timerEn && !runCmd) |=> state == ST_IDLE);

  a_r4_halt_sleeps: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && coreHalt && timerEn && !runCmd) |=> state == ST_SLEEP);
endmodule

// File: rtl/sleepSequencer.sv
module sleepSequencer
  import seqPkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int ADDR_W   = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [2:0]          cfgAddr,
  input  logic [PERIOD_W-1:0] cfgWrData,
  input  logic                runCmd,
  input  logic [ADDR_W-1:0]   runAddr,
  input  logic                coreHalt,
  input  logic                instrValid,
  input  logic [31:0]         instr,
  output logic                coreStart,
  output logic [ADDR_W-1:0]   startAddr,
  output logic                wakeOut
);
  seqStrobe_t strobe;
  logic       timerEn;
  logic       restartDue;

  seqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .runCmd     (runCmd),
    .coreHalt   (coreHalt),
    .instrValid (instrValid),
    .instr      (instr),
    .timerEn    (timerEn),
    .restartDue (restartDue),
    .strobe     (strobe),
    .coreStart  (coreStart),
    .wakeOut    (wakeOut)
  );

  seqData #(.PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .runCmd     (runCmd),
    .runAddr    (runAddr),
    .strobe     (strobe),
    .timerEn    (timerEn),
    .restartDue (restartDue),
    .startAddr  (startAddr)
  );
endmodule

// File: tb/tb_sleepSequencer.sv
module tb_sleepSequencer;
  localparam int PERIOD_W = 16;
  localparam int ADDR_W   = 11;
  localparam int NROWS    = 5;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cfgWrEn = 1'b0;
  logic [2:0]          cfgAddr = '0;
  logic [PERIOD_W-1:0] cfgWrData = '0;
  logic                runCmd = 1'b0;
  logic [ADDR_W-1:0]   runAddr = '0;
  logic                coreHalt = 1'b0;
  logic                instrValid = 1'b0;
  logic [31:0]         instr = '0;
  logic                coreStart;
  logic [ADDR_W-1:0]   startAddr;
  logic                wakeOut;

  int nChecks = 0;
  int nFails  = 0;
  int lat;

  // each row: selector, period value, expected restart latency (P+1)
  localparam logic [3:0]  VSEL [NROWS] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd3};
  localparam logic [15:0] VPER [NROWS] = '{16'd3, 16'd0, 16'd7, 16'd1, 16'd12};
  localparam int          VLAT [NROWS] = '{4, 1, 8, 2, 13};

  always #4 clk = ~clk;

  sleepSequencer #(.PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .runCmd(runCmd), .runAddr(runAddr),
    .coreHalt(coreHalt), .instrValid(instrValid), .instr(instr),
    .coreStart(coreStart), .startAddr(startAddr), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [PERIOD_W-1:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic runWith(input logic [ADDR_W-1:0] a);
    @(negedge clk); runCmd = 1'b1; runAddr = a;
    @(negedge clk); runCmd = 1'b0;
    check("R3 start pulse", int'(coreStart), 1);
    check("R3 start address", int'(startAddr), int'(a));
    @(negedge clk);
    check("R3 single-cycle pulse", int'(coreStart), 0);
  endtask

  // returns the number of falling edges from the halt cycle to the start pulse, 0 if none
  task automatic haltMeasure(input int limit, output int n);
    @(negedge clk); coreHalt = 1'b1;
    @(negedge clk); coreHalt = 1'b0;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (coreStart && n == 0) n = i;
    end
  endtask

  task automatic sendInstr(input logic [31:0] w, output int wakeNow, output int wakeAfter,
                           output int startSeen);
    @(negedge clk); instrValid = 1'b1; instr = w;
    @(negedge clk); instrValid = 1'b0; instr = '0;
    wakeNow = int'(wakeOut); startSeen = int'(coreStart);
    @(negedge clk);
    wakeAfter = int'(wakeOut); startSeen = startSeen | int'(coreStart);
  endtask

  function automatic logic [31:0] selInstr(input logic [3:0] idx);
    return {4'd9, 3'd1, 21'd0, idx};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int w0, w1, st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 coreStart after reset", int'(coreStart), 0);
    check("R1 wakeOut after reset", int'(wakeOut), 0);
    check("R1 startAddr after reset", int'(startAddr), 0);

    // R9 / R1: timer disabled, engine not running, halt ignored
    haltMeasure(20, lat);
    check("R9 halt while idle", lat, 0);

    runWith(11'h02A);

    // table walk: R2 period writes, R5 selector writes, R4 latency
    for (int r = 0; r < NROWS; r++) begin
      cfgWrite(3'(VSEL[r]), VPER[r]);
      cfgWrite(3'd5, 16'(VSEL[r]));
      haltMeasure(VLAT[r] + 6, lat);
      check("R4 restart latency", lat, VLAT[r]);
      check("R4 restart address", int'(startAddr), 'h02A);
    end

    // R6 period-select instruction picks register 2 (period 7)
    sendInstr(selInstr(4'd2), w0, w1, st);
    haltMeasure(20, lat);
    check("R6 select by instruction", lat, 8);
    sendInstr(selInstr(4'd6), w0, w1, st);
    haltMeasure(20, lat);
    check("R6 out-of-range index ignored", lat, 8);
    cfgWrite(3'd5, 16'd5);
    haltMeasure(20, lat);
    check("R5 selector 5 ignored", lat, 8);
    cfgWrite(3'd5, 16'd1);
    haltMeasure(20, lat);
    check("R5 selector write to 1", lat, 1);

    // R7 wake request
    sendInstr({4'd9, 3'd0, 24'd0, 1'b1}, w0, w1, st);
    check("R7 wake pulse", w0, 1);
    check("R7 wake one cycle", w1, 0);
    check("R7 wake leaves engine alone", st, 0);
    haltMeasure(20, lat);
    check("R7 restarts continue after wake", lat, 1);
    sendInstr({4'd9, 3'd0, 24'd0, 1'b0}, w0, w1, st);
    check("R7 no wake without bit 0", w0, 0);

    // R8 timer disabled while running
    cfgWrite(3'd6, 16'd0);
    haltMeasure(40, lat);
    check("R8 no restart when disabled", lat, 0);
    runWith(11'h111);

    // R8 disabled while counting toward a long period
    cfgWrite(3'd5, 16'd3);
    @(negedge clk); coreHalt = 1'b1;
    @(negedge clk); coreHalt = 1'b0;
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = 3'd6; cfgWrData = 16'd0;
    @(negedge clk); cfgWrEn = 1'b0;
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (coreStart && lat == 0) lat = i;
    end
    check("R8 pending restart cancelled", lat, 0);
    runWith(11'h0F0);
    haltMeasure(20, lat);
    check("R8 run re-enables timer", lat, 13);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule